// File: doc/BRIEF.md
# Handshake Side-Channel Update Scheduler

This block carries three slow side channels (request-to-send, terminal-ready and a ring-indicate line) across a link next to the main serial data. On the transmit side it decides when a three-bit handshake update word goes into the transmit queue. Two things start an update. One is an edge on either of the two main handshake inputs. The other is a periodic refresh timer. A two-bit bandwidth select sets the shortest gap allowed between two updates. A change that arrives inside that gap is held as pending and sent when the gap ends, so it is never lost. The same select also drives an extra-compression enable for the data path; this enable is active at the lowest bandwidth setting.

The transmit side is a three-state machine:
- `ST_IDLE` moves to `ST_REQ` on a detected change or when the refresh timer is due.
- `ST_REQ` holds the write request high until the queue accepts the word. On acceptance it moves to `ST_HOLD`.
- `ST_HOLD` counts out the minimum gap. At the end of the gap it goes to `ST_REQ` if a change is pending, a change is present or the refresh is due. Otherwise it returns to `ST_IDLE`.

The word is always built from the newest synchronised input values.

On the receive side, each far-end word that is marked valid updates three held outputs:
- far-end request-to-send drives local clear-to-send;
- far-end terminal-ready drives local set-ready;
- far-end ring-indicate drives local ring output.

Top module: `hs_update_sched`

## Requirements
- R1: A change on `rts_in` or `dtr_in` seen while idle raises `upd_valid` so that the word is accepted 3 clock edges after the input changed: two edges for synchronisation, then one for the request. Word bit 0 is RTS, bit 1 is DTR and bit 2 is ring-indicate, each taken from the newest synchronised values.
- R2: A change on `ring_in` alone starts no update. Its value travels only inside words that are started by other causes.
- R3: With no input activity, accepted updates repeat exactly every `INTERVAL` cycles.
- R4: After an accepted update, the next acceptance comes no earlier than the gap chosen by `bw_sel` at that acceptance: `SPACE_00`, `SPACE_01`, `SPACE_10` or `SPACE_11` cycles.
- R5: Changes that arrive during the gap are deferred. An update is accepted exactly when the gap ends, and it carries the latest values.
- R6: `super_compress` is 1 when `bw_sel` is 2'b00 and 0 for the other three codes.
- R7: While `upd_ready` is low, `upd_valid` stays high and `upd_word` follows the latest input values. `upd_valid` falls only after a cycle in which `upd_ready` was high.
- R8: A cycle with `far_valid` high loads `far_word` bit 0 into `cts_out`, bit 1 into `dsr_out` and bit 2 into `ring_out` on the next edge. Without `far_valid` those outputs hold their values.
- R9: During reset `upd_valid`, `cts_out`, `dsr_out` and `ring_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| bw_sel | input | 2 | Update bandwidth select |
| rts_in | input | 1 | Local request-to-send, asynchronous |
| dtr_in | input | 1 | Local terminal-ready, asynchronous |
| ring_in | input | 1 | Local ring-indicate, asynchronous |
| upd_ready | input | 1 | Transmit queue can take a word |
| upd_valid | output | 1 | Update word write request |
| upd_word | output | 3 | Update word {ring, dtr, rts} |
| super_compress | output | 1 | Extra compression enable |
| far_valid | input | 1 | Received far-end word is valid |
| far_word | input | 3 | Received far-end word {ring, dtr, rts} |
| cts_out | output | 1 | Local clear-to-send from far-end RTS |
| dsr_out | output | 1 | Local set-ready from far-end DTR |
| ring_out | output | 1 | Local ring output from far-end ring-indicate |

## Verification
The gap property assumes that `bw_sel` only changes while no acceptance is in flight. The checker stores the gap at each acceptance, so a later change of code affects only the following gap. The bench changes the code only after a gap has fully run out and then forces a fresh acceptance under the new code. The request-hold property assumes that the queue may drop `upd_ready` at any time. The bench holds `upd_ready` low across several input changes to exercise this.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_HOLD = 2'd2
    } sched_st_t;

    typedef struct packed {
        logic ring;
        logic dtr;
        logic rts;
    } hs_word_t;

    localparam int HS_BITS = $bits(hs_word_t);

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[i]   <= 1'b0;
                sync_out[i] <= 1'b0;
            end else begin
                stage1[i]   <= async_in[i];
                sync_out[i] <= stage1[i];
            end
        end
    end

endmodule

// File: rtl/hs_pace.sv
module hs_pace #(
    parameter int INTERVAL = 16000,
    parameter int SPACE_00 = 16667,
    parameter int SPACE_01 = 1000,
    parameter int SPACE_10 = 2000,
    parameter int SPACE_11 = 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bw_sel,
    input  logic       accept,
    output logic       hold_done,
    output logic       refresh_due
);

    import hs_pkg::*;

    localparam int MAXV = max_of4(INTERVAL, max_of4(SPACE_00, SPACE_01, SPACE_10, SPACE_11), 2, 2);
    localparam int CW   = $clog2(MAXV + 1);

    localparam logic [CW-1:0] LOAD_00  = CW'(SPACE_00 - 2);
    localparam logic [CW-1:0] LOAD_01  = CW'(SPACE_01 - 2);
    localparam logic [CW-1:0] LOAD_10  = CW'(SPACE_10 - 2);
    localparam logic [CW-1:0] LOAD_11  = CW'(SPACE_11 - 2);
    localparam logic [CW-1:0] SINCE_MAX = CW'(INTERVAL - 1);
    localparam logic [CW-1:0] DUE_AT    = CW'(INTERVAL - 2);

    logic [CW-1:0] hold_cnt;
    logic [CW-1:0] since_cnt;
    logic [CW-1:0] load_val;

    always_comb begin
        unique case (bw_sel)
            2'b00:   load_val = LOAD_00;
            2'b01:   load_val = LOAD_01;
            2'b10:   load_val = LOAD_10;
            default: load_val = LOAD_11;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (accept) begin
            hold_cnt <= load_val;
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_cnt <= '0;
        end else if (accept) begin
            since_cnt <= '0;
        end else if (since_cnt != SINCE_MAX) begin
            since_cnt <= since_cnt + 1'b1;
        end
    end

    assign hold_done   = (hold_cnt == '0);
    assign refresh_due = (since_cnt >= DUE_AT);

endmodule

// File: rtl/hs_tx_fsm.sv
module hs_tx_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic change,
    input  logic hold_done,
    input  logic refresh_due,
    input  logic upd_ready,
    output logic upd_valid,
    output logic accept
);

    import hs_pkg::*;

    sched_st_t state, state_nxt;
    logic      pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (change || refresh_due) state_nxt = ST_REQ;
            end
            ST_REQ: begin
                if (upd_ready) state_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (hold_done) begin
                    if (pending || change || refresh_due) state_nxt = ST_REQ;
                    else                                  state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (state == ST_HOLD && !hold_done) begin
            if (change) pending <= 1'b1;
        end else begin
            pending <= 1'b0;
        end
    end

    always_comb begin
        upd_valid = 1'b0;
        unique case (state)
            ST_REQ:  upd_valid = 1'b1;
            default: upd_valid = 1'b0;
        endcase
        accept = upd_valid && upd_ready;
    end

endmodule

// File: rtl/hs_rx_latch.sv
module hs_rx_latch (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             far_valid,
    input  hs_pkg::hs_word_t far_word,
    output logic             cts_out,
    output logic             dsr_out,
    output logic             ring_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cts_out  <= 1'b0;
            dsr_out  <= 1'b0;
            ring_out <= 1'b0;
        end else if (far_valid) begin
            cts_out  <= far_word.rts;
            dsr_out  <= far_word.dtr;
            ring_out <= far_word.ring;
        end
    end

endmodule

// File: rtl/hs_update_sched.sv
module hs_update_sched #(
    parameter int INTERVAL = 16000,
    parameter int SPACE_00 = 16667,
    parameter int SPACE_01 = 1000,
    parameter int SPACE_10 = 2000,
    parameter int SPACE_11 = 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bw_sel,
    input  logic       rts_in,
    input  logic       dtr_in,
    input  logic       ring_in,
    input  logic       upd_ready,
    output logic       upd_valid,
    output logic [2:0] upd_word,
    output logic       super_compress,
    input  logic       far_valid,
    input  logic [2:0] far_word,
    output logic       cts_out,
    output logic       dsr_out,
    output logic       ring_out
);

    import hs_pkg::*;

    hs_word_t raw_in, sync_w, prev_w;
    logic     change, hold_done, refresh_due, accept;

    assign raw_in = '{ring: ring_in, dtr: dtr_in, rts: rts_in};

    hs_sync #(.WIDTH(HS_BITS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (sync_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_w <= '0;
        else        prev_w <= sync_w;
    end

    assign change = (sync_w.rts ^ prev_w.rts) | (sync_w.dtr ^ prev_w.dtr);

    hs_pace #(
        .INTERVAL (INTERVAL),
        .SPACE_00 (SPACE_00),
        .SPACE_01 (SPACE_01),
        .SPACE_10 (SPACE_10),
        .SPACE_11 (SPACE_11)
    ) u_pace (
        .clk         (clk),
        .rst_n       (rst_n),
        .bw_sel      (bw_sel),
        .accept      (accept),
        .hold_done   (hold_done),
        .refresh_due (refresh_due)
    );

    hs_tx_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .change      (change),
        .hold_done   (hold_done),
        .refresh_due (refresh_due),
        .upd_ready   (upd_ready),
        .upd_valid   (upd_valid),
        .accept      (accept)
    );

    assign upd_word       = sync_w;
    assign super_compress = (bw_sel == 2'b00);

    hs_rx_latch u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .far_valid (far_valid),
        .far_word  (hs_word_t'(far_word)),
        .cts_out   (cts_out),
        .dsr_out   (dsr_out),
        .ring_out  (ring_out)
    );

endmodule

// File: rtl/hs_update_sched_chk.sv
module hs_update_sched_chk #(
    parameter int SPACE_00 = 16667,
    parameter int SPACE_01 = 1000,
    parameter int SPACE_10 = 2000,
    parameter int SPACE_11 = 4000
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bw_sel,
    input logic       upd_valid,
    input logic       upd_ready,
    input logic       far_valid,
    input logic [2:0] far_word,
    input logic       cts_out,
    input logic       dsr_out,
    input logic       ring_out
);

    localparam int MAXS = hs_pkg::max_of4(SPACE_00, SPACE_01, SPACE_10, SPACE_11);
    localparam int GW   = $clog2(MAXS + 2);

    logic          acc, seen;
    logic [GW-1:0] gap, need;

    assign acc = upd_valid && upd_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap  <= '0;
            need <= '0;
            seen <= 1'b0;
        end else if (acc) begin
            gap  <= '0;
            seen <= 1'b1;
            unique case (bw_sel)
                2'b00:   need <= GW'(SPACE_00);
                2'b01:   need <= GW'(SPACE_01);
                2'b10:   need <= GW'(SPACE_10);
                default: need <= GW'(SPACE_11);
            endcase
        end else if (gap != {GW{1'b1}}) begin
            gap <= gap + 1'b1;
        end
    end

    p_min_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && seen) |-> (gap >= need - 1'b1));

    p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_ready) |=> upd_valid);

    p_drop_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upd_valid) |-> $past(upd_ready));

    p_rx_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        far_valid |=> ({ring_out, dsr_out, cts_out} == $past(far_word)));

    p_rx_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !far_valid |=> $stable({ring_out, dsr_out, cts_out}));

endmodule

bind hs_update_sched hs_update_sched_chk #(
    .SPACE_00 (SPACE_00),
    .SPACE_01 (SPACE_01),
    .SPACE_10 (SPACE_10),
    .SPACE_11 (SPACE_11)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bw_sel    (bw_sel),
    .upd_valid (upd_valid),
    .upd_ready (upd_ready),
    .far_valid (far_valid),
    .far_word  (far_word),
    .cts_out   (cts_out),
    .dsr_out   (dsr_out),
    .ring_out  (ring_out)
);

// File: tb/sim_hs_update_sched.sv
module sim_hs_update_sched;

    localparam int IV  = 300;
    localparam int S00 = 150;
    localparam int S01 = 10;
    localparam int S10 = 20;
    localparam int S11 = 40;

    // Receive-path vectors: {far_word[2:0], expected {ring_out, dsr_out, cts_out}}
    localparam logic [5:0] RXV [8] = '{
        6'b001_001, 6'b011_011, 6'b111_111, 6'b000_000,
        6'b100_100, 6'b010_010, 6'b101_101, 6'b110_110
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bw_sel;
    logic       rts_in, dtr_in, ring_in, upd_ready;
    logic       upd_valid, super_compress;
    logic [2:0] upd_word;
    logic       far_valid;
    logic [2:0] far_word;
    logic       cts_out, dsr_out, ring_out;

    always #4 clk = ~clk;

    hs_update_sched #(
        .INTERVAL (IV),
        .SPACE_00 (S00),
        .SPACE_01 (S01),
        .SPACE_10 (S10),
        .SPACE_11 (S11)
    ) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .bw_sel         (bw_sel),
        .rts_in         (rts_in),
        .dtr_in         (dtr_in),
        .ring_in        (ring_in),
        .upd_ready      (upd_ready),
        .upd_valid      (upd_valid),
        .upd_word       (upd_word),
        .super_compress (super_compress),
        .far_valid      (far_valid),
        .far_word       (far_word),
        .cts_out        (cts_out),
        .dsr_out        (dsr_out),
        .ring_out       (ring_out)
    );

    int         cyc = 0;
    int         acc_cnt = 0;
    int         acc_cyc = 0;
    logic [2:0] acc_word = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && upd_valid && upd_ready) begin
            acc_cnt  <= acc_cnt + 1;
            acc_cyc  <= cyc;
            acc_word <= upd_word;
        end
    end

    int vecs = 0;
    int bad  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_acc(input int maxc, output bit got);
        int s;
        s   = acc_cnt;
        got = 1'b0;
        for (int i = 0; i < maxc && !got; i++) begin
            @(negedge clk);
            if (acc_cnt != s) got = 1'b1;
        end
    endtask

    function automatic int space_of(input logic [1:0] c);
        case (c)
            2'b00:   return S00;
            2'b01:   return S01;
            2'b10:   return S10;
            default: return S11;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        vecs++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        bit         got;
        int         c, a, n;
        logic [2:0] expw;

        bw_sel    = 2'b01;
        rts_in    = 1'b0;
        dtr_in    = 1'b0;
        ring_in   = 1'b0;
        upd_ready = 1'b1;
        far_valid = 1'b0;
        far_word  = 3'b000;

        repeat (3) @(negedge clk);
        // R9: reset state
        chk(upd_valid == 1'b0, "R9 upd_valid", upd_valid, 0);
        chk({ring_out, dsr_out, cts_out} == 3'b000, "R9 rx outputs",
            {ring_out, dsr_out, cts_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: receive vector table
        for (int v = 0; v < 8; v++) begin
            far_word  = RXV[v][5:3];
            far_valid = 1'b1;
            @(negedge clk);
            far_valid = 1'b0;
            chk({ring_out, dsr_out, cts_out} == RXV[v][2:0], "R8 load",
                {ring_out, dsr_out, cts_out}, RXV[v][2:0]);
            far_word = ~RXV[v][5:3];
            repeat (2) @(negedge clk);
            chk({ring_out, dsr_out, cts_out} == RXV[v][2:0], "R8 hold",
                {ring_out, dsr_out, cts_out}, RXV[v][2:0]);
        end

        // R6: compression enable per code
        for (int k = 0; k < 4; k++) begin
            bw_sel = 2'(k);
            #1;
            chk(super_compress == (k == 0), "R6 super_compress", super_compress, (k == 0));
        end
        bw_sel = 2'b01;

        // R3: first periodic update arrives
        wait_acc(IV + 20, got);
        chk(got, "R3 periodic present", got, 1);

        // R1: RTS edge from idle, accepted 3 edges later
        repeat (20) @(negedge clk);
        c = cyc;
        rts_in = 1'b1;
        wait_acc(20, got);
        chk(got && (acc_cyc - c == 3), "R1 latency", acc_cyc - c, 3);
        chk(acc_word == 3'b001, "R1 word", acc_word, 3'b001);

        // R2: ring-indicate change alone starts nothing
        repeat (15) @(negedge clk);
        n = acc_cnt;
        ring_in = 1'b1;
        repeat (40) @(negedge clk);
        chk(acc_cnt == n, "R2 no trigger", acc_cnt - n, 0);
        dtr_in = 1'b1;
        wait_acc(20, got);
        chk(got && acc_word == 3'b111, "R1 dtr word carries ring", acc_word, 3'b111);

        // R3: exact refresh period with no activity
        wait_acc(IV + 20, got);
        a = acc_cyc;
        wait_acc(IV + 20, got);
        chk(got && (acc_cyc - a == IV), "R3 period", acc_cyc - a, IV);

        // R4 / R5: gap per code and deferred changes
        for (int k = 0; k < 4; k++) begin
            bw_sel = 2'(k);
            rts_in = ~rts_in;
            wait_acc(IV + 200, got);
            a = acc_cyc;
            rts_in = ~rts_in;
            repeat (2) @(negedge clk);
            dtr_in = ~dtr_in;
            expw = {ring_in, dtr_in, rts_in};
            wait_acc(IV + 200, got);
            chk(got && (acc_cyc - a == space_of(2'(k))), "R4 gap",
                acc_cyc - a, space_of(2'(k)));
            chk(acc_word == expw, "R5 deferred word", acc_word, expw);
        end

        // R7: back-pressure holds request and tracks latest values
        bw_sel = 2'b01;
        repeat (S00 + 5) @(negedge clk);
        upd_ready = 1'b0;
        dtr_in = ~dtr_in;
        repeat (10) @(negedge clk);
        chk(upd_valid == 1'b1, "R7 request held", upd_valid, 1);
        n = acc_cnt;
        rts_in = ~rts_in;
        repeat (4) @(negedge clk);
        expw = {ring_in, dtr_in, rts_in};
        chk(upd_word == expw, "R7 word tracks", upd_word, expw);
        chk(acc_cnt == n && upd_valid, "R7 still waiting", acc_cnt - n, 0);
        upd_ready = 1'b1;
        wait_acc(5, got);
        chk(got && acc_word == expw, "R7 accepted word", acc_word, expw);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule